// File: doc/BRIEF.md
# Indirect Paged Register Access Bridge

This block answers management-register transactions addressed to one fixed PHY address and turns them into accesses on a wide internal register bus. A host cannot see the internal space directly: it first selects a page, then writes an offset together with a read or write opcode, and moves the value through four 16-bit data words. The opcode bits stay set while the internal access is in flight and clear when the internal bus reports ready. The host polls them to learn that the access has finished.

Serial framing is handled elsewhere. The bridge receives already decoded transactions: a write or read strobe, a 5-bit PHY address, a 5-bit register number and 16 bits of write data. It returns read data in the same cycle. On the internal side it presents a page, an offset, a 64-bit write value and one request strobe per direction. Each strobe is held until `ib_ready` is sampled high, so the internal register file sets the latency.

Top module: `paged_reg_bridge`

## Requirements
- R1: Only transactions at PHY address 30 have any effect. Writes at any other address change no state. Reads at any other address return 0x0000.
- R2: Register 0x10 holds the page number in bits 15:8. A write updates the page only when bit 0 is 1. Reading the register returns {page, 7'b0, valid}, where valid is set once a page has been accepted. `ib_page` shows the accepted page.
- R3: A write to register 0x11 with bit 0 set starts an internal write. A write with bit 1 set starts an internal read. Bits 15:8 of that same write are latched as the offset and driven on `ib_offset`.
- R4: Reading register 0x11 returns {offset, 6'b0, read_pending, write_pending}. The pending bit is visible on the first poll after the opcode write, and both bits read 0 in the cycle after completion.
- R5: Registers 0x18 to 0x1B are data words 0 to 3. `ib_wdata` equals {word3, word2, word1, word0}, so word 0 carries the least significant 16 bits.
- R6: An internal write stores the current `ib_wdata` at the selected page and offset when it completes.
- R7: When an internal read completes, the four data words are loaded from `ib_rdata`, with word 0 taking bits 15:0.
- R8: An opcode write with both bits set starts a read and never a write.
- R9: While an access is pending, writes to the page register, the opcode register and the data words are ignored, and `ib_page` and `ib_offset` stay unchanged.
- R10: Reads of unimplemented registers at address 30 return 0x0000. Writes to them change no readable register.
- R11: A request strobe stays high for exactly N+1 cycles when `ib_ready` rises N cycles after the request. Only one strobe is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_wr | input | 1 | Decoded management write strobe |
| mdio_rd | input | 1 | Decoded management read strobe |
| mdio_phy | input | 5 | PHY address of the transaction |
| mdio_regnum | input | 5 | Register number of the transaction |
| mdio_wdata | input | 16 | Write data |
| mdio_rdata | output | 16 | Read data, combinational |
| ib_page | output | 8 | Internal page |
| ib_offset | output | 8 | Internal offset |
| ib_wr | output | 1 | Internal write request, held until ready |
| ib_rd | output | 1 | Internal read request, held until ready |
| ib_wdata | output | 64 | Internal write value |
| ib_rdata | input | 64 | Internal read value |
| ib_ready | input | 1 | Completion of the current request |

## Verification
The hardest situation to create is a management write that arrives while an internal access is still in flight, because a fast responder finishes before the host can act. The bench model of the internal register file therefore has a programmable ready latency. It is stretched to twenty cycles, and opcode, page and data writes are issued inside that window. Their rejection is then confirmed through the offset, the page and the data word that the completed read leaves behind. The same latency control gives exact strobe lengths at latency zero and latency six.

// File: rtl/pgbr_pkg.sv
package pgbr_pkg;
   localparam int MGMT_DW = 16;
   localparam int MGMT_AW = 5;
   localparam logic [MGMT_AW-1:0] DEF_PHY_ADDR  = 5'd30;
   localparam logic [MGMT_AW-1:0] DEF_PAGE_REG  = 5'h10;
   localparam logic [MGMT_AW-1:0] DEF_OP_REG    = 5'h11;
   localparam logic [MGMT_AW-1:0] DEF_DATA_BASE = 5'h18;
   typedef enum logic [1:0] {
      OPB_WRITE = 2'd0,
      OPB_READ  = 2'd1
   } op_bit_e;
endpackage

// File: rtl/pgbr_window_dec.sv
module pgbr_window_dec
   import pgbr_pkg::*;
#(
   parameter logic [MGMT_AW-1:0] PHY_ADDR  = DEF_PHY_ADDR,
   parameter logic [MGMT_AW-1:0] PAGE_REG  = DEF_PAGE_REG,
   parameter logic [MGMT_AW-1:0] OP_REG    = DEF_OP_REG,
   parameter logic [MGMT_AW-1:0] DATA_BASE = DEF_DATA_BASE,
   parameter int                 NUM_WORDS = 4
) (
   input  logic [MGMT_AW-1:0] phy,
   input  logic [MGMT_AW-1:0] regnum,
   input  logic               wr_en,
   output logic               page_hit,
   output logic               op_hit,
   output logic               page_we,
   output logic               op_we,
   output logic [NUM_WORDS-1:0] data_hit,
   output logic [NUM_WORDS-1:0] data_we
);
   logic addr_ok;

   assign addr_ok  = (phy == PHY_ADDR);
   assign page_hit = addr_ok && (regnum == PAGE_REG);
   assign op_hit   = addr_ok && (regnum == OP_REG);
   assign page_we  = page_hit && wr_en;
   assign op_we    = op_hit && wr_en;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int SLOT = int'(DATA_BASE) + w;
      assign data_hit[w] = addr_ok && (int'(regnum) == SLOT);
      assign data_we[w]  = data_hit[w] && wr_en;
   end
endmodule

// File: rtl/pgbr_op_seq.sv
module pgbr_op_seq #(
   parameter int PAGE_W = 8,
   parameter int OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_we,
   input  logic              op_we,
   input  logic [1:0]        wr_lo,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic              ib_ready,
   output logic [PAGE_W-1:0] page_q,
   output logic              page_valid,
   output logic [OFS_W-1:0]  ofs_q,
   output logic              wr_pend,
   output logic              rd_pend,
   output logic              busy,
   output logic              rd_done
);
   import pgbr_pkg::*;
   logic done;

   assign busy    = wr_pend | rd_pend;
   assign done    = busy & ib_ready;
   assign rd_done = rd_pend & ib_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q     <= '0;
         page_valid <= 1'b0;
      end else if (page_we && !busy && wr_lo[0]) begin
         page_q     <= wr_page;
         page_valid <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q   <= '0;
         wr_pend <= 1'b0;
         rd_pend <= 1'b0;
      end else if (done) begin
         wr_pend <= 1'b0;
         rd_pend <= 1'b0;
      end else if (op_we && !busy && (wr_lo != 2'b00)) begin
         ofs_q   <= wr_ofs;
         rd_pend <= wr_lo[OPB_READ];
         wr_pend <= !wr_lo[OPB_READ];
      end
   end
endmodule

// File: rtl/pgbr_data_buf.sv
module pgbr_data_buf #(
   parameter int NUM_WORDS = 4,
   parameter int WORD_W    = 16,
   localparam int DATA_W   = NUM_WORDS * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WORDS-1:0] data_we,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 lock,
   input  logic                 load,
   input  logic [DATA_W-1:0]    load_val,
   output logic [DATA_W-1:0]    words
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[w*WORD_W +: WORD_W] <= '0;
         end else if (load) begin
            words[w*WORD_W +: WORD_W] <= load_val[w*WORD_W +: WORD_W];
         end else if (data_we[w] && !lock) begin
            words[w*WORD_W +: WORD_W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
   import pgbr_pkg::*;
#(
   parameter logic [4:0] PHY_ADDR  = DEF_PHY_ADDR,
   parameter logic [4:0] PAGE_REG  = DEF_PAGE_REG,
   parameter logic [4:0] OP_REG    = DEF_OP_REG,
   parameter logic [4:0] DATA_BASE = DEF_DATA_BASE,
   parameter int         NUM_WORDS = 4,
   parameter int         WORD_W    = 16,
   parameter int         PAGE_W    = 8,
   parameter int         OFS_W     = 8,
   localparam int        DATA_W    = NUM_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdio_wr,
   input  logic              mdio_rd,
   input  logic [4:0]        mdio_phy,
   input  logic [4:0]        mdio_regnum,
   input  logic [15:0]       mdio_wdata,
   output logic [15:0]       mdio_rdata,
   output logic [PAGE_W-1:0] ib_page,
   output logic [OFS_W-1:0]  ib_offset,
   output logic              ib_wr,
   output logic              ib_rd,
   output logic [DATA_W-1:0] ib_wdata,
   input  logic [DATA_W-1:0] ib_rdata,
   input  logic              ib_ready
);
   if (WORD_W != MGMT_DW) begin : g_bad_word_w
      $error("WORD_W must equal the management data width");
   end
   if (NUM_WORDS < 1 || int'(DATA_BASE) + NUM_WORDS > 32) begin : g_bad_words
      $error("data words must fit inside the 32-register window");
   end
   if (PAGE_W < 1 || PAGE_W > 8 || OFS_W < 1 || OFS_W > 8) begin : g_bad_addr_w
      $error("page and offset widths must be 1 to 8 bits");
   end

   logic                 page_hit, op_hit, page_we, op_we;
   logic [NUM_WORDS-1:0] data_hit, data_we;
   logic [PAGE_W-1:0]    page_q;
   logic                 page_valid;
   logic [OFS_W-1:0]     ofs_q;
   logic                 wr_pend, rd_pend, busy, rd_done;
   logic [DATA_W-1:0]    words;
   logic [15:0]          page_view, op_view;

   pgbr_window_dec #(
      .PHY_ADDR (PHY_ADDR),
      .PAGE_REG (PAGE_REG),
      .OP_REG   (OP_REG),
      .DATA_BASE(DATA_BASE),
      .NUM_WORDS(NUM_WORDS)
   ) u_dec (
      .phy     (mdio_phy),
      .regnum  (mdio_regnum),
      .wr_en   (mdio_wr),
      .page_hit(page_hit),
      .op_hit  (op_hit),
      .page_we (page_we),
      .op_we   (op_we),
      .data_hit(data_hit),
      .data_we (data_we)
   );

   pgbr_op_seq #(
      .PAGE_W(PAGE_W),
      .OFS_W (OFS_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_we   (page_we),
      .op_we     (op_we),
      .wr_lo     (mdio_wdata[1:0]),
      .wr_page   (mdio_wdata[8 +: PAGE_W]),
      .wr_ofs    (mdio_wdata[8 +: OFS_W]),
      .ib_ready  (ib_ready),
      .page_q    (page_q),
      .page_valid(page_valid),
      .ofs_q     (ofs_q),
      .wr_pend   (wr_pend),
      .rd_pend   (rd_pend),
      .busy      (busy),
      .rd_done   (rd_done)
   );

   pgbr_data_buf #(
      .NUM_WORDS(NUM_WORDS),
      .WORD_W   (WORD_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (data_we),
      .wdata   (mdio_wdata),
      .lock    (busy),
      .load    (rd_done),
      .load_val(ib_rdata),
      .words   (words)
   );

   assign ib_page   = page_q;
   assign ib_offset = ofs_q;
   assign ib_wr     = wr_pend;
   assign ib_rd     = rd_pend;
   assign ib_wdata  = words;

   always_comb begin
      page_view = '0;
      page_view[8 +: PAGE_W] = page_q;
      page_view[0] = page_valid;
      op_view = '0;
      op_view[8 +: OFS_W] = ofs_q;
      op_view[OPB_READ]  = rd_pend;
      op_view[OPB_WRITE] = wr_pend;
   end

   always_comb begin
      mdio_rdata = '0;
      if (mdio_rd) begin
         if (page_hit) mdio_rdata = page_view;
         if (op_hit)   mdio_rdata = op_view;
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (data_hit[w]) mdio_rdata = words[w*WORD_W +: WORD_W];
         end
      end
   end
endmodule

// File: rtl/pgbr_checker.sv
module pgbr_checker #(
   parameter logic [4:0] PHY_ADDR  = 5'd30,
   parameter logic [4:0] PAGE_REG  = 5'h10,
   parameter logic [4:0] OP_REG    = 5'h11,
   parameter logic [4:0] DATA_BASE = 5'h18,
   parameter int         NUM_WORDS = 4,
   parameter int         PAGE_W    = 8,
   parameter int         OFS_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdio_wr,
   input logic              mdio_rd,
   input logic [4:0]        mdio_phy,
   input logic [4:0]        mdio_regnum,
   input logic [1:0]        op_bits,
   input logic [OFS_W-1:0]  ofs_bits,
   input logic [15:0]       mdio_rdata,
   input logic [PAGE_W-1:0] ib_page,
   input logic [OFS_W-1:0]  ib_offset,
   input logic              ib_wr,
   input logic              ib_rd,
   input logic              ib_ready
);
   localparam int DLO = int'(DATA_BASE);
   localparam int DHI = DLO + NUM_WORDS;

   logic busy, at_me, op_start, unmapped;
   assign busy     = ib_wr | ib_rd;
   assign at_me    = (mdio_phy == PHY_ADDR);
   assign op_start = mdio_wr && at_me && (mdio_regnum == OP_REG) && (op_bits != 2'b00) && !busy;
   assign unmapped = (mdio_regnum != PAGE_REG) && (mdio_regnum != OP_REG) &&
                     (int'(mdio_regnum) < DLO || int'(mdio_regnum) >= DHI);

   assert_foreign_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_rd && !at_me) |-> (mdio_rdata == 16'h0000));

   assert_foreign_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_wr && !at_me && !busy) |=> (!busy && $stable(ib_page)));

   assert_start_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> (busy && ib_offset == $past(ofs_bits)));

   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ib_ready) |=> !busy);

   assert_read_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_bits == 2'b11) |=> (ib_rd && !ib_wr));

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ib_ready) |=> ($stable(ib_page) && $stable(ib_offset)));

   assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_rd && at_me && unmapped) |-> (mdio_rdata == 16'h0000));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ib_ready) |=> ($stable(ib_rd) && $stable(ib_wr)));

   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ib_rd, ib_wr}));
endmodule

bind paged_reg_bridge pgbr_checker #(
   .PHY_ADDR (PHY_ADDR),
   .PAGE_REG (PAGE_REG),
   .OP_REG   (OP_REG),
   .DATA_BASE(DATA_BASE),
   .NUM_WORDS(NUM_WORDS),
   .PAGE_W   (PAGE_W),
   .OFS_W    (OFS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mdio_wr    (mdio_wr),
   .mdio_rd    (mdio_rd),
   .mdio_phy   (mdio_phy),
   .mdio_regnum(mdio_regnum),
   .op_bits    (mdio_wdata[1:0]),
   .ofs_bits   (mdio_wdata[8 +: OFS_W]),
   .mdio_rdata (mdio_rdata),
   .ib_page    (ib_page),
   .ib_offset  (ib_offset),
   .ib_wr      (ib_wr),
   .ib_rd      (ib_rd),
   .ib_ready   (ib_ready)
);

// File: tb/sim_paged_reg_bridge.sv
module sim_paged_reg_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdio_wr = 1'b0, mdio_rd = 1'b0;
   logic [4:0]  mdio_phy = '0, mdio_regnum = '0;
   logic [15:0] mdio_wdata = '0;
   logic [15:0] mdio_rdata;
   logic [7:0]  ib_page, ib_offset;
   logic        ib_wr, ib_rd, ib_ready;
   logic [63:0] ib_wdata, ib_rdata;

   int checks = 0;
   int failures = 0;
   int lat = 0;
   int cnt = 0;

   logic [63:0] mem [0:255];
   logic        written [0:255];
   logic [7:0]  idx;

   always #4 clk = ~clk;

   paged_reg_bridge u0 (
      .clk(clk), .rst_n(rst_n),
      .mdio_wr(mdio_wr), .mdio_rd(mdio_rd), .mdio_phy(mdio_phy),
      .mdio_regnum(mdio_regnum), .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata),
      .ib_page(ib_page), .ib_offset(ib_offset), .ib_wr(ib_wr), .ib_rd(ib_rd),
      .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ib_ready(ib_ready)
   );

   function automatic logic [63:0] seed(input logic [7:0] i);
      return {i, 8'hC3, ~i, 8'h3C, i ^ 8'h55, 8'h96, i + 8'd1, 8'h69};
   endfunction

   assign idx      = {ib_page[3:0], ib_offset[3:0]};
   assign ib_ready = (ib_rd || ib_wr) && (cnt >= lat);
   assign ib_rdata = written[idx] ? mem[idx] : seed(idx);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) written[i] <= 1'b0;
      end else if (ib_wr && ib_ready) begin
         mem[idx]     <= ib_wdata;
         written[idx] <= 1'b1;
      end
   end

   always @(posedge clk) cnt <= (ib_rd || ib_wr) ? cnt + 1 : 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic mwr(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
      @(negedge clk);
      mdio_phy = phy; mdio_regnum = rn; mdio_wdata = d; mdio_wr = 1'b1;
      @(negedge clk);
      mdio_wr = 1'b0;
   endtask

   task automatic mrd(input logic [4:0] phy, input logic [4:0] rn, output logic [15:0] d);
      @(negedge clk);
      mdio_phy = phy; mdio_regnum = rn; mdio_rd = 1'b1;
      #1 d = mdio_rdata;
      mdio_rd = 1'b0;
   endtask

   task automatic poll_done(input string req);
      logic [15:0] v;
      int n = 0;
      do begin
         mrd(5'd30, 5'h11, v);
         n++;
      end while (v[1:0] != 2'b00 && n < 200);
      chk(req, {62'd0, v[1:0]}, 64'd0);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      mrd(5'd30, 5'h10, v); chk("R2 reset page", v, 0);
      mrd(5'd30, 5'h11, v); chk("R4 reset op", v, 0);
      mrd(5'd30, 5'h1B, v); chk("R5 reset word3", v, 0);
      chk("R11 reset strobes", {ib_rd, ib_wr}, 0);
   endtask

   task automatic t_page;
      logic [15:0] v;
      mwr(5'd30, 5'h10, 16'h0301);
      mrd(5'd30, 5'h10, v); chk("R2 page readback", v, 16'h0301);
      chk("R2 ib_page", ib_page, 8'h03);
      mwr(5'd30, 5'h10, 16'h0700);
      mrd(5'd30, 5'h10, v); chk("R2 no enable bit", v, 16'h0301);
   endtask

   task automatic t_foreign;
      logic [15:0] v;
      mwr(5'd5, 5'h10, 16'h0901);
      mrd(5'd30, 5'h10, v); chk("R1 foreign page write", v, 16'h0301);
      mrd(5'd5, 5'h10, v);  chk("R1 foreign read", v, 0);
      mwr(5'd29, 5'h11, 16'h0202);
      chk("R1 foreign op write", {ib_rd, ib_wr}, 0);
   endtask

   task automatic t_write64;
      logic [15:0] v;
      lat = 3;
      mwr(5'd30, 5'h18, 16'h1111);
      mwr(5'd30, 5'h19, 16'h2222);
      mwr(5'd30, 5'h1A, 16'h3333);
      mwr(5'd30, 5'h1B, 16'h4444);
      chk("R5 word order", ib_wdata, 64'h4444_3333_2222_1111);
      mwr(5'd30, 5'h11, 16'h0501);
      mrd(5'd30, 5'h11, v); chk("R4 busy on next poll", v, 16'h0501);
      chk("R3 offset latched", ib_offset, 8'h05);
      poll_done("R4 write completes");
      chk("R6 stored value", mem[8'h35], 64'h4444_3333_2222_1111);
   endtask

   task automatic t_read64;
      logic [15:0] v;
      logic [63:0] got;
      lat = 0;
      mwr(5'd30, 5'h10, 16'h0201);
      mwr(5'd30, 5'h11, 16'h0902);
      poll_done("R4 read completes");
      for (int w = 0; w < 4; w++) begin
         mrd(5'd30, 5'(8'h18 + w), v);
         got[w*16 +: 16] = v;
      end
      chk("R7 read value", got, seed(8'h29));
   endtask

   task automatic t_both;
      logic [15:0] v;
      lat = 2;
      mwr(5'd30, 5'h11, 16'h0A03);
      chk("R8 read strobe only", {ib_rd, ib_wr}, 2'b10);
      poll_done("R8 completes");
      mrd(5'd30, 5'h1A, v); chk("R8 read data", v, seed(8'h2A)[47:32]);
      chk("R8 no store", written[8'h2A], 1'b0);
   endtask

   task automatic t_busy_ignore;
      logic [15:0] v;
      lat = 20;
      mwr(5'd30, 5'h11, 16'h0102);
      mwr(5'd30, 5'h11, 16'h0C01);
      mwr(5'd30, 5'h18, 16'hFFFF);
      mwr(5'd30, 5'h10, 16'h0501);
      chk("R9 offset held", ib_offset, 8'h01);
      chk("R9 page held", ib_page, 8'h02);
      chk("R9 strobes", {ib_rd, ib_wr}, 2'b10);
      poll_done("R9 completes");
      mrd(5'd30, 5'h11, v); chk("R9 op readback", v, 16'h0100);
      mrd(5'd30, 5'h18, v); chk("R9 data word kept", v, seed(8'h21)[15:0]);
      mrd(5'd30, 5'h10, v); chk("R9 page reg", v, 16'h0201);
   endtask

   task automatic t_latency;
      int n;
      for (int k = 0; k < 2; k++) begin
         lat = (k == 0) ? 6 : 0;
         mwr(5'd30, 5'h11, 16'h0302);
         n = 0;
         while (ib_rd && n < 100) begin
            n++;
            @(negedge clk);
         end
         chk("R11 strobe length", n, lat + 1);
      end
   endtask

   task automatic t_unmapped;
      logic [15:0] v;
      mwr(5'd30, 5'h12, 16'hBEEF);
      mwr(5'd30, 5'h00, 16'hBEEF);
      mrd(5'd30, 5'h12, v); chk("R10 read 0x12", v, 0);
      mrd(5'd30, 5'h1F, v); chk("R10 read 0x1F", v, 0);
      mrd(5'd30, 5'h10, v); chk("R10 page untouched", v, 16'h0201);
      mrd(5'd30, 5'h11, v); chk("R10 op untouched", v, 16'h0300);
      mrd(5'd30, 5'h19, v); chk("R10 data untouched", v, seed(8'h23)[31:16]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_page();
      t_foreign();
      t_write64();
      t_read64();
      t_both();
      t_busy_ignore();
      t_latency();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule